// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a processor that keeps several procedure frames on chip at once. Software always sees 32 logical registers, each 32 bits wide. A 3-bit window pointer picks which slice of a 138-entry physical array backs those registers. Ten logical registers are global, and every window reaches the same physical copies of them. The other 22 are split into three groups: six incoming argument registers, ten locals and six outgoing argument registers.

Neighbouring windows overlap. The six outgoing registers of a caller are the same physical storage as the six incoming registers of the callee, so arguments and results pass without any copying. A call strobe moves the pointer down by one window and a return strobe moves it up by one, both modulo the window count. The windowed area wraps circularly.

The block counts how many caller frames are held on chip. It raises a one-cycle trap flag when a call would run onto a frame still in use, and when a return finds no frame left to go back to. Saving frames to memory and restoring them belong to the trap handler and are not part of this block.

Top module: `win_regfile`

## Requirements
- R1: After a synchronous active-high reset the window pointer is 0, both trap flags are 0, and every logical register reads 0 in every window.
- R2: Logical register 0 always reads 0 on both read ports. A write to it is ignored, including in the same cycle as a read of it.
- R3: Logical registers 1 to 9 are globals. A value written to one of them in any window reads back unchanged in every other window.
- R4: Logical registers 10 to 15 (incoming), 16 to 25 (locals) and 26 to 31 (outgoing) belong to the current window. Window w takes its outgoing group from physical windowed slots w*16+0..5, its locals from w*16+6..15 and its incoming group from w*16+16..21, all modulo 128. The locals of the eight windows are therefore disjoint.
- R5: Outgoing register 26+k written in window w reads back as incoming register 10+k in window w-1 (mod 8), for k from 0 to 5, and the same holds in the opposite direction after a return. This includes the wrap from window 0 to window 7.
- R6: A call strobe alone decrements the window pointer by one modulo 8 at the clock edge. A return strobe alone increments it by one modulo 8.
- R7: With seven calls outstanding, a further call leaves the pointer unchanged. The overflow flag is then 1 for the cycle after that edge.
- R8: With no calls outstanding, a return leaves the pointer unchanged. The underflow flag is then 1 for the cycle after that edge.
- R9: A call and a return asserted in the same cycle cancel. The pointer does not move and neither flag rises.
- R10: When a read port addresses the register being written in the same cycle, it returns the new write data before the clock edge.
- R11: Reads and writes in the cycle that carries a call or return use the window pointer as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_reg | input | 5 | Logical register number for read port 0 |
| rd0_data | output | 32 | Read port 0 data (combinational) |
| rd1_reg | input | 5 | Logical register number for read port 1 |
| rd1_data | output | 32 | Read port 1 data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 5 | Logical register number to write |
| wr_data | input | 32 | Write data |
| win_call | input | 1 | Call strobe: move to the next lower window |
| win_ret | input | 1 | Return strobe: move to the next higher window |
| cwp | output | 3 | Current window pointer |
| ovf_trap | output | 1 | Window overflow flag, one cycle per refused call |
| unf_trap | output | 1 | Window underflow flag, one cycle per refused return |

## Verification
The main check fills all 31 writable registers with a value unique to each window. It then calls through all eight windows and returns back through them, reading all 32 registers on both ports in every window. A wrong offset for any of the three groups, a missing overlap or a global that is not shared shows up as a mismatch against an arithmetic model of the mapping.

Separate patterns target the edge cases. Out-to-in passing across the window 7/0 wrap tells a true modulo wrap from a clamp. Refused calls and returns at full and empty depth tell the trap path from a silent move. A same-cycle write and read of one register tells bypassed data from stale storage. A write issued together with a call tells old-pointer timing from new-pointer timing.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int unsigned LREG_W      = 5;
    localparam int unsigned NUM_GLOBAL  = 10;
    localparam int unsigned IN_FIRST    = 10;
    localparam int unsigned LOCAL_FIRST = 16;
    localparam int unsigned OUT_FIRST   = 26;
    localparam int unsigned NUM_SHARED  = 6;
    localparam int unsigned NUM_LOCAL   = 10;
    localparam int unsigned WIN_STRIDE  = NUM_SHARED + NUM_LOCAL;

    typedef enum logic [2:0] {
        WIN_HOLD,
        WIN_CALL,
        WIN_RET,
        WIN_OVF,
        WIN_UNF
    } win_act_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_GLOBAL,
        CLS_WINDOW
    } reg_class_e;

    typedef struct packed {
        logic              en;
        logic [LREG_W-1:0] lreg;
    } wr_req_t;

    function automatic reg_class_e classify(input logic [LREG_W-1:0] lreg);
        int unsigned r = 32'(lreg);
        if (r == 0)
            return CLS_ZERO;
        else if (r < NUM_GLOBAL)
            return CLS_GLOBAL;
        else
            return CLS_WINDOW;
    endfunction

    // slot relative to the start of the current window; outgoing group sits
    // lowest so that it coincides with the incoming group of the window below
    function automatic int unsigned window_slot(input logic [LREG_W-1:0] lreg);
        int unsigned r = 32'(lreg);
        if (r < LOCAL_FIRST)
            return WIN_STRIDE + (r - IN_FIRST);
        else if (r < OUT_FIRST)
            return NUM_SHARED + (r - LOCAL_FIRST);
        else
            return r - OUT_FIRST;
    endfunction

    function automatic int unsigned phys_index(input logic [LREG_W-1:0] lreg,
                                               input int unsigned       cwp,
                                               input int unsigned       nwin);
        if (classify(lreg) != CLS_WINDOW)
            return 32'(lreg);
        return NUM_GLOBAL + ((cwp * WIN_STRIDE + window_slot(lreg)) % (nwin * WIN_STRIDE));
    endfunction

endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate
    import wrf_pkg::*;
#(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned CWP_W   = 3,
    parameter int unsigned PHYS_W  = 8
) (
    input  logic [LREG_W-1:0] lreg_i,
    input  logic [CWP_W-1:0]  cwp_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              zero_o
);

    int unsigned cwp_int;

    always_comb begin
        cwp_int = {{(32-CWP_W){1'b0}}, cwp_i};
        zero_o  = (classify(lreg_i) == CLS_ZERO);
        phys_o  = PHYS_W'(phys_index(lreg_i, cwp_int, NUM_WIN));
    end

endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl
    import wrf_pkg::*;
#(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned CWP_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [CWP_W-1:0] cwp_o,
    output logic             ovf_o,
    output logic             unf_o
);

    localparam logic [CWP_W-1:0] DEPTH_FULL = CWP_W'(NUM_WIN - 1);

    logic [CWP_W-1:0] cwp_q;
    logic [CWP_W-1:0] depth_q;
    logic             ovf_q;
    logic             unf_q;
    win_act_e         act;

    always_comb begin
        act = WIN_HOLD;
        if (call_i && !ret_i)
            act = (depth_q == DEPTH_FULL) ? WIN_OVF : WIN_CALL;
        else if (ret_i && !call_i)
            act = (depth_q == '0) ? WIN_UNF : WIN_RET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q   <= '0;
            depth_q <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            ovf_q <= (act == WIN_OVF);
            unf_q <= (act == WIN_UNF);
            case (act)
                WIN_CALL: begin
                    cwp_q   <= cwp_q - 1'b1;
                    depth_q <= depth_q + 1'b1;
                end
                WIN_RET: begin
                    cwp_q   <= cwp_q + 1'b1;
                    depth_q <= depth_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cwp_o = cwp_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PHYS = 138,
    parameter int unsigned PHYS_W   = 8,
    parameter int unsigned NUM_RD   = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [PHYS_W-1:0]              waddr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [NUM_RD-1:0][PHYS_W-1:0]  raddr_i,
    input  logic [NUM_RD-1:0]              rzero_i,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o
);

    logic [DATA_W-1:0] mem [NUM_PHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NUM_PHYS); i++)
                mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (rzero_i[p])
                rdata_o[p] = '0;
            else if (we_i && (waddr_i == raddr_i[p]))
                rdata_o[p] = wdata_i;
            else
                rdata_o[p] = mem[raddr_i[p]];
        end
    end

endmodule

// File: rtl/win_regfile.sv
module win_regfile
    import wrf_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_WIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        rd0_reg,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [4:0]        rd1_reg,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_call,
    input  logic              win_ret,
    output logic [$clog2(NUM_WIN)-1:0] cwp,
    output logic              ovf_trap,
    output logic              unf_trap
);

    localparam int unsigned CWP_W    = $clog2(NUM_WIN);
    localparam int unsigned NUM_PHYS = NUM_GLOBAL + NUM_WIN * WIN_STRIDE;
    localparam int unsigned PHYS_W   = $clog2(NUM_PHYS);
    localparam int unsigned NUM_RD   = 2;
    localparam int unsigned NUM_XL   = NUM_RD + 1;

    logic [CWP_W-1:0]                 cwp_cur;
    logic [NUM_XL-1:0][LREG_W-1:0]    xl_lreg;
    logic [NUM_XL-1:0][PHYS_W-1:0]    xl_phys;
    logic [NUM_XL-1:0]                xl_zero;
    logic [NUM_RD-1:0][PHYS_W-1:0]    rd_phys;
    logic [NUM_RD-1:0][DATA_W-1:0]    rd_data;
    wr_req_t                          wreq;
    logic                             wr_live;

    // index 0 is the write port, then the read ports in order
    assign xl_lreg = {rd1_reg, rd0_reg, wr_reg};

    for (genvar x = 0; x < NUM_XL; x++) begin : g_xl
        wrf_xlate #(
            .NUM_WIN (NUM_WIN),
            .CWP_W   (CWP_W),
            .PHYS_W  (PHYS_W)
        ) i_xlate (
            .lreg_i (xl_lreg[x]),
            .cwp_i  (cwp_cur),
            .phys_o (xl_phys[x]),
            .zero_o (xl_zero[x])
        );
    end

    assign wreq    = '{en: wr_en, lreg: wr_reg};
    assign wr_live = wreq.en && !xl_zero[0];
    assign rd_phys = {xl_phys[2], xl_phys[1]};

    wrf_window_ctl #(
        .NUM_WIN (NUM_WIN),
        .CWP_W   (CWP_W)
    ) i_ctl (
        .clk    (clk),
        .rst    (rst),
        .call_i (win_call),
        .ret_i  (win_ret),
        .cwp_o  (cwp_cur),
        .ovf_o  (ovf_trap),
        .unf_o  (unf_trap)
    );

    wrf_storage #(
        .DATA_W   (DATA_W),
        .NUM_PHYS (NUM_PHYS),
        .PHYS_W   (PHYS_W),
        .NUM_RD   (NUM_RD)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (wr_live),
        .waddr_i (xl_phys[0]),
        .wdata_i (wr_data),
        .raddr_i (rd_phys),
        .rzero_i (xl_zero[2:1]),
        .rdata_o (rd_data)
    );

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];
    assign cwp      = cwp_cur;

endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CWP_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        rd0_reg,
    input logic [DATA_W-1:0] rd0_data,
    input logic [4:0]        rd1_reg,
    input logic [DATA_W-1:0] rd1_data,
    input logic              wr_en,
    input logic [4:0]        wr_reg,
    input logic [DATA_W-1:0] wr_data,
    input logic              win_call,
    input logic              win_ret,
    input logic [CWP_W-1:0]  cwp,
    input logic              ovf_trap,
    input logic              unf_trap
);

    // R2
    zero_rd0_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_reg == 5'd0) |-> (rd0_data == '0));

    // R2
    zero_rd1_chk: assert property (@(posedge clk) disable iff (rst)
        (rd1_reg == 5'd0) |-> (rd1_data == '0));

    // R6
    call_move_chk: assert property (@(posedge clk) disable iff (rst)
        (win_call && !win_ret) |=> (ovf_trap || (cwp == CWP_W'($past(cwp) - 1'b1))));

    // R6
    ret_move_chk: assert property (@(posedge clk) disable iff (rst)
        (win_ret && !win_call) |=> (unf_trap || (cwp == CWP_W'($past(cwp) + 1'b1))));

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> ($stable(cwp) && $past(win_call) && !$past(win_ret)));

    // R8
    unf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        unf_trap |-> ($stable(cwp) && $past(win_ret) && !$past(win_call)));

    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (win_call == win_ret) |=> ($stable(cwp) && !ovf_trap && !unf_trap));

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_reg != 5'd0) && (rd0_reg == wr_reg)) |-> (rd0_data == wr_data));

endmodule

bind win_regfile win_regfile_chk #(
    .DATA_W (DATA_W),
    .CWP_W  (CWP_W)
) u_chk (.*);

// File: tb/test_win_regfile.sv
module test_win_regfile;

    localparam int DW   = 32;
    localparam int NW   = 8;
    localparam int NPHY = 10 + NW * 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    rd0_reg, rd1_reg, wr_reg;
    logic [DW-1:0] rd0_data, rd1_data, wr_data;
    logic          wr_en, win_call, win_ret;
    logic [2:0]    cwp;
    logic          ovf_trap, unf_trap;

    always #5 clk = ~clk;

    win_regfile i_win_regfile (
        .clk(clk), .rst(rst),
        .rd0_reg(rd0_reg), .rd0_data(rd0_data),
        .rd1_reg(rd1_reg), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
        .win_call(win_call), .win_ret(win_ret),
        .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] mdl [NPHY];
    int m_cwp, m_depth;

    // arithmetic model of the mapping in R3/R4/R5
    function automatic int mphys(int c, int r);
        if (r < 10) return r;
        if (r < 16) return 10 + (((c + 1) * 16 + (r - 10)) % (NW * 16));
        if (r < 26) return 10 + ((c * 16 + 6 + (r - 16)) % (NW * 16));
        return 10 + ((c * 16 + (r - 26)) % (NW * 16));
    endfunction

    function automatic logic [DW-1:0] mexp(int r);
        return (r == 0) ? '0 : mdl[mphys(m_cwp, r)];
    endfunction

    function automatic logic [DW-1:0] pat(int c, int r);
        return {8'(c + 8'h10), 8'(r), 16'(16'hA5C3 ^ (c * 37 + r * 11))};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic rchk(int a, int b, string tag);
        rd0_reg = 5'(a);
        rd1_reg = 5'(b);
        #1;
        chk(rd0_data === mexp(a), tag, $sformatf("cwp%0d rd0 r%0d", m_cwp, a), rd0_data, mexp(a));
        chk(rd1_data === mexp(b), tag, $sformatf("cwp%0d rd1 r%0d", m_cwp, b), rd1_data, mexp(b));
    endtask

    // one cycle; rpre >= 0 samples read port 0 before the edge (old pointer)
    task automatic tick(bit we, int wr, logic [DW-1:0] wd, bit c, bit r, int rpre, string tag);
        bit e_ovf = 1'b0;
        bit e_unf = 1'b0;
        logic [DW-1:0] e_rd;
        wr_en = we; wr_reg = 5'(wr); wr_data = wd;
        win_call = c; win_ret = r;
        if (rpre >= 0) begin
            rd0_reg = 5'(rpre);
            #1;
            e_rd = (we && rpre == wr && rpre != 0) ? wd : mexp(rpre);
            chk(rd0_data === e_rd, tag, $sformatf("pre-edge r%0d", rpre), rd0_data, e_rd);
        end
        @(posedge clk);
        if (we && wr != 0) mdl[mphys(m_cwp, wr)] = wd;
        if (c && !r) begin
            if (m_depth == NW - 1) e_ovf = 1'b1;
            else begin m_cwp = (m_cwp + NW - 1) % NW; m_depth++; end
        end else if (r && !c) begin
            if (m_depth == 0) e_unf = 1'b1;
            else begin m_cwp = (m_cwp + 1) % NW; m_depth--; end
        end
        @(negedge clk);
        wr_en = 1'b0; win_call = 1'b0; win_ret = 1'b0;
        #1;
        chk(int'(cwp) == m_cwp, tag, "cwp", 32'(cwp), 32'(m_cwp));
        chk(ovf_trap == e_ovf, tag, "ovf_trap", 32'(ovf_trap), 32'(e_ovf));
        chk(unf_trap == e_unf, tag, "unf_trap", 32'(unf_trap), 32'(e_unf));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_reg = '0; wr_data = '0;
        win_call = 1'b0; win_ret = 1'b0; rd0_reg = '0; rd1_reg = '0;
        for (int i = 0; i < NPHY; i++) mdl[i] = '0;
        m_cwp = 0; m_depth = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // R1: reset state
        chk(cwp == 3'd0, "R1", "cwp", 32'(cwp), 0);
        chk(!ovf_trap && !unf_trap, "R1", "flags", {30'b0, ovf_trap, unf_trap}, 0);
        for (int r = 0; r < 32; r++) rchk(r, 31 - r, "R1");

        // R2: writes to r0 ignored, also during a same-cycle read
        tick(1'b1, 0, 32'hDEADBEEF, 1'b0, 1'b0, 0, "R2");
        rchk(0, 0, "R2");

        // R3/R4/R6: fill every window while calling down through all of them
        for (int w = 0; w < NW; w++) begin
            for (int r = 1; r < 32; r++) tick(1'b1, r, pat(m_cwp, r), 1'b0, 1'b0, -1, "R4");
            for (int r = 0; r < 32; r++) rchk(r, (r + 7) % 32, (r < 10) ? "R3" : "R4");
            if (w < NW - 1) tick(1'b0, 0, '0, 1'b1, 1'b0, -1, "R6");
        end
        // R7: eighth call refused
        tick(1'b0, 0, '0, 1'b1, 1'b0, -1, "R7");
        tick(1'b0, 0, '0, 1'b1, 1'b0, -1, "R7");
        // R3/R4/R6: walk back and verify every window kept its contents
        for (int w = 0; w < NW; w++) begin
            for (int r = 0; r < 32; r++) rchk(r, 31 - r, (r < 10) ? "R3" : "R4");
            if (w < NW - 1) tick(1'b0, 0, '0, 1'b0, 1'b1, -1, "R6");
        end
        // R8: return with nothing outstanding
        tick(1'b0, 0, '0, 1'b0, 1'b1, -1, "R8");

        // R9: simultaneous strobes cancel, even at empty depth
        tick(1'b0, 0, '0, 1'b1, 1'b1, -1, "R9");

        // R5: out -> in across the 0 -> 7 wrap, then in -> out on return
        for (int k = 0; k < 6; k++) tick(1'b1, 26 + k, 32'h5000_0000 + 32'(k), 1'b0, 1'b0, -1, "R5");
        tick(1'b0, 0, '0, 1'b1, 1'b0, -1, "R5");
        for (int k = 0; k < 6; k++) begin
            rd0_reg = 5'(10 + k);
            #1;
            chk(rd0_data === 32'h5000_0000 + 32'(k), "R5", $sformatf("in r%0d", 10 + k),
                rd0_data, 32'h5000_0000 + 32'(k));
        end
        tick(1'b1, 15, 32'h6600_0015, 1'b0, 1'b0, -1, "R5");
        tick(1'b0, 0, '0, 1'b0, 1'b1, -1, "R5");
        rd0_reg = 5'd31;
        #1;
        chk(rd0_data === 32'h6600_0015, "R5", "out r31", rd0_data, 32'h6600_0015);

        // R10: same-cycle write and read return new data
        tick(1'b1, 20, 32'hB1B2_B3B4, 1'b0, 1'b0, 20, "R10");
        tick(1'b1, 5, 32'h0BAD_0005, 1'b0, 1'b0, 5, "R10");
        rchk(20, 5, "R10");

        // R11: write and read in a call cycle use the old window
        tick(1'b1, 18, 32'hC0DE_0018, 1'b1, 1'b0, 19, "R11");
        rchk(18, 19, "R11");
        tick(1'b0, 0, '0, 1'b0, 1'b1, 18, "R11");
        rd0_reg = 5'd18;
        #1;
        chk(rd0_data === 32'hC0DE_0018, "R11", "old-window r18", rd0_data, 32'hC0DE_0018);

        summary();
        $finish;
    end

endmodule